// File: doc/BRIEF.md
# Windowed Watchdog with Key Sequence

This block is a watchdog timer that software keeps alive through a single byte-wide service register. A restart takes two ordered writes: first the arming byte 0x55, then the firing byte 0xAA. Any amount of time may pass between the two writes. A 3-bit rate code sets the timeout length, and code zero switches the whole watchdog off. If the timeout runs out, or if software writes anything illegal, the block raises a one-clock reset request for the chip's reset controller.

An optional window mode guards against runaway code that services the watchdog too often. With the window on, service writes are legal only in the final quarter of the period. Any write in the first three quarters counts as a violation. The service register gives no information back when read.

The timeout length for code c is 2^(BASE_LOG + STEP_LOG*c) clock cycles. With the defaults (12 and 2) this is 2^(12+2c). A simulation build can shrink both parameters.

Top module: `wdog_key_window`

## Requirements
- R1: While `rate_sel` is 0 the watchdog is off. Writes of any value to the service register are ignored and `wd_rst` stays low.
- R2: While enabled, a service write of any byte other than 0x55 or 0xAA makes `wd_rst` go high in the cycle after the write.
- R3: A write of 0xAA that follows a 0x55 write in the current sequence restarts the timeout, even when other cycles separate the two writes. The next expiry then comes a full period after the 0xAA write.
- R4: While enabled, if no restart happens, `wd_rst` pulses once every period. The counter starts at 0 when the watchdog is enabled, reset, or restarted. The pulse appears in the cycle after the count has reached period−1.
- R5: Several 0x55 writes in a row are legal and keep the sequence armed. A later 0xAA still restarts the timeout.
- R6: A write of 0xAA with no preceding 0x55 in the current sequence makes `wd_rst` go high in the next cycle.
- R7: With `win_en` high, any service write made while the count is below three quarters of the period makes `wd_rst` go high in the next cycle. A 0x55/0xAA pair written at counts at or above that boundary restarts the timeout normally.
- R8: `wd_rst` is high for one cycle per event. A watchdog event clears both the counter and the armed state, so a lone 0xAA right after an event is again a violation.
- R9: `svc_rdata` always reads 0x00.
- R10: The period for rate code c (1 to 7) is 2^(BASE_LOG + STEP_LOG*c) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| svc_wr | input | 1 | Write strobe for the service register |
| svc_wdata | input | 8 | Write data for the service register |
| svc_rdata | output | 8 | Read data of the service register, always zero |
| rate_sel | input | 3 | Timeout rate code; 0 disables the watchdog |
| win_en | input | 1 | Window mode enable |
| wd_rst | output | 1 | One-cycle watchdog reset request |

## Verification
The bench tries the key protocol with several write patterns, and each pattern separates one pair of behaviours:
- A split 0x55 … 0xAA pair shows that a restart does not need back-to-back writes.
- A run of repeated 0x55 writes shows that extra arming bytes are harmless.
- A lone 0xAA, sent both fresh and right after a violation, shows that an event drops the armed state.
- Stray bytes, including 0x00 and 0xFF, show the immediate violation path.

In window mode, writes land one count below the boundary and exactly on it, so any off-by-one in the boundary compare shows up. Free-running expiry is timed for several rate codes and compared against the power-of-two formula.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  // Timeout length in cycles for a rate code.
  function automatic longint unsigned span_of(input int unsigned code,
                                              input int unsigned base,
                                              input int unsigned step);
    return 64'd1 << (base + step * code);
  endfunction

  // First count at which service writes are legal in window mode.
  function automatic longint unsigned open_of(input longint unsigned span);
    return span - (span >> 2);
  endfunction

endpackage

// File: rtl/wdog_rate_table.sv
module wdog_rate_table #(
  parameter int unsigned BASE_LOG = 12,
  parameter int unsigned STEP_LOG = 2,
  parameter int unsigned CNT_W    = BASE_LOG + STEP_LOG * 7 + 1
) (
  input  logic [2:0]       rate_sel,
  output logic             enable,
  output logic [CNT_W-1:0] last_cnt,
  output logic [CNT_W-1:0] open_cnt
);
  localparam int unsigned CODES = 8;

  logic [CNT_W-1:0] last_tbl [CODES];
  logic [CNT_W-1:0] open_tbl [CODES];

  for (genvar c = 0; c < CODES; c++) begin : g_code
    localparam longint unsigned SPAN = wdog_pkg::span_of(c, BASE_LOG, STEP_LOG);
    assign last_tbl[c] = CNT_W'(SPAN - 64'd1);
    assign open_tbl[c] = CNT_W'(wdog_pkg::open_of(SPAN));
  end

  assign enable   = (rate_sel != 3'd0);
  assign last_cnt = last_tbl[rate_sel];
  assign open_cnt = open_tbl[rate_sel];

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned CNT_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clear,
  input  logic [CNT_W-1:0] last_cnt,
  output logic [CNT_W-1:0] count,
  output logic             at_last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (!enable || clear)
      count <= '0;
    else
      count <= count + CNT_W'(1);
  end

  // ">=" also covers a shorter rate picked while counting.
  assign at_last = (count >= last_cnt);

  a_r4_wraps_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && clear) |=> (count == '0));

endmodule

// File: rtl/wdog_key_track.sv
module wdog_key_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       early,
  input  logic       bite,
  output logic       fault,
  output logic       service,
  output logic       armed
);
  logic is_arm, is_fire, wr_on;

  assign wr_on   = enable && wr;
  assign is_arm  = (wdata == wdog_pkg::KEY_ARM);
  assign is_fire = (wdata == wdog_pkg::KEY_FIRE);

  assign fault   = wr_on && (!(is_arm || is_fire) || early || (is_fire && !armed));
  assign service = wr_on && is_fire && armed && !early;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      armed <= 1'b0;
    else if (!enable || bite || service)
      armed <= 1'b0;
    else if (wr_on && is_arm)
      armed <= 1'b1;
  end

  a_r5_arm_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_on && is_arm && !bite) |=> armed);

  a_r8_fault_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !armed);

endmodule

// File: rtl/wdog_key_window.sv
module wdog_key_window #(
  parameter int unsigned BASE_LOG = 12,
  parameter int unsigned STEP_LOG = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       svc_wr,
  input  logic [7:0] svc_wdata,
  output logic [7:0] svc_rdata,
  input  logic [2:0] rate_sel,
  input  logic       win_en,
  output logic       wd_rst
);
  localparam int unsigned CNT_W = BASE_LOG + STEP_LOG * 7 + 1;

  logic             enable;
  logic [CNT_W-1:0] last_cnt, open_cnt, count;
  logic             at_last, early, fault, service, armed, expire, bite;

  wdog_rate_table #(.BASE_LOG(BASE_LOG), .STEP_LOG(STEP_LOG), .CNT_W(CNT_W)) u_rate (
    .rate_sel(rate_sel), .enable(enable), .last_cnt(last_cnt), .open_cnt(open_cnt));

  wdog_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clear(bite || service),
    .last_cnt(last_cnt), .count(count), .at_last(at_last));

  assign early = win_en && (count < open_cnt);

  wdog_key_track u_key (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr(svc_wr), .wdata(svc_wdata),
    .early(early), .bite(bite), .fault(fault), .service(service), .armed(armed));

  assign expire = enable && at_last && !service;
  assign bite   = fault || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_rst <= 1'b0;
    else        wd_rst <= bite;
  end

  assign svc_rdata = 8'h00;

  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 3'd0) |=> !wd_rst);

  a_r2_stray_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && svc_wr && svc_wdata != 8'h55 && svc_wdata != 8'hAA) |=> wd_rst);

  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    service |=> (count == '0 && !wd_rst));

  a_r4_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && at_last && !svc_wr) |=> wd_rst);

  a_r6_fire_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && svc_wr && svc_wdata == 8'hAA && !armed) |=> wd_rst);

  a_r7_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && win_en && svc_wr && count < open_cnt) |=> wd_rst);

  a_r8_event_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |-> (count == '0 && !armed));

endmodule

// File: tb/tb_wdog_key_window.sv
module tb_wdog_key_window;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 4;
  localparam int STEP = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [2:0] rate = 3'd0;
  logic       win = 1'b0;
  logic [7:0] rdata;
  logic       wdr;

  int    errors = 0;
  int    checks = 0;
  int    pulses = 0;
  bit    done = 0;
  string tag = "reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_key_window #(.BASE_LOG(BASE), .STEP_LOG(STEP)) dut (
    .clk(clk), .rst_n(rst_n), .svc_wr(wr), .svc_wdata(wd), .svc_rdata(rdata),
    .rate_sel(rate), .win_en(win), .wd_rst(wdr));

  // Behavioural reference model
  longint m_cnt, m_p, m_open;
  bit     m_armed, m_rst, m_early, m_fault, m_svc, m_bite;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_armed = 0; m_rst = 0;
    end else if (rate == 0) begin
      m_cnt = 0; m_armed = 0; m_rst = 0;
    end else begin
      m_p    = longint'(1) << (BASE + STEP * int'(rate));
      m_open = (m_p * 3) / 4;
      m_early = win && (m_cnt < m_open);
      m_fault = wr && ((wd != 8'h55 && wd != 8'hAA) || m_early || (wd == 8'hAA && !m_armed));
      m_svc   = wr && wd == 8'hAA && m_armed && !m_early;
      m_bite  = m_fault || (m_cnt >= m_p - 1 && !m_svc);
      m_rst   = m_bite;
      if (m_bite || m_svc) begin
        m_cnt = 0; m_armed = 0;
      end else begin
        m_cnt = m_cnt + 1;
        if (wr && wd == 8'h55) m_armed = 1;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    chk(wdr == m_rst, tag, "wd_rst vs model", wdr, m_rst);
    chk(rdata == 8'h00, "R9", "read data", rdata, 0);
    if (wdr) pulses++;
    wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) cycle();
  endtask

  task automatic wr_byte(logic [7:0] v);
    wr = 1'b1; wd = v;
    cycle();
  endtask

  task automatic restart(logic [2:0] r, logic w);
    rate = 3'd0; win = 1'b0;
    idle(2);
    rate = r; win = w;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      cycle();
      n++;
    end while (!wdr && n < 5000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, p0;
    idle(2);
    chk(wdr == 1'b0, "R4", "wd_rst in reset", wdr, 0);
    chk(rdata == 8'h00, "R9", "rdata in reset", rdata, 0);
    rst_n = 1'b1;
    idle(2);

    // R1: disabled, writes ignored
    tag = "R1";
    p0 = pulses;
    rate = 3'd0; win = 1'b1;
    wr_byte(8'h12); wr_byte(8'hAA); idle(5); wr_byte(8'h55);
    idle(80);
    chk(pulses == p0, "R1", "pulses while off", pulses - p0, 0);

    // R10 / R4: free-running periods
    for (int c = 1; c <= 4; c++) begin
      tag = "R10";
      restart(3'(c), 1'b0);
      wait_pulse(n);
      chk(n == (1 << (BASE + STEP * c)), "R10", "first period", n, 1 << (BASE + STEP * c));
      tag = "R4";
      wait_pulse(n);
      chk(n == (1 << (BASE + STEP * c)), "R4", "repeat period", n, 1 << (BASE + STEP * c));
    end
    tag = "R10";
    restart(3'd7, 1'b0);
    wait_pulse(n);
    chk(n == (1 << (BASE + STEP * 7)), "R10", "code 7 period", n, 1 << (BASE + STEP * 7));

    // R3: split key pair restarts
    tag = "R3";
    restart(3'd1, 1'b0);
    idle(10); wr_byte(8'h55); idle(4); wr_byte(8'hAA);
    chk(wdr == 1'b0, "R3", "no event on service", wdr, 0);
    wait_pulse(n);
    chk(n == 32, "R3", "period after service", n, 32);

    // R5: repeated arm bytes
    tag = "R5";
    restart(3'd1, 1'b0);
    wr_byte(8'h55); idle(2); wr_byte(8'h55); idle(2); wr_byte(8'h55); wr_byte(8'hAA);
    chk(wdr == 1'b0, "R5", "no event after repeated arm", wdr, 0);
    wait_pulse(n);
    chk(n == 32, "R5", "period after service", n, 32);

    // R2: stray bytes
    tag = "R2";
    restart(3'd2, 1'b0);
    idle(5);
    wr_byte(8'h3C);
    chk(wdr == 1'b1, "R2", "stray 0x3C", wdr, 1);
    cycle();
    chk(wdr == 1'b0, "R8", "pulse one cycle", wdr, 0);
    wr_byte(8'h00);
    chk(wdr == 1'b1, "R2", "stray 0x00", wdr, 1);
    idle(3);
    wr_byte(8'hFF);
    chk(wdr == 1'b1, "R2", "stray 0xFF", wdr, 1);

    // R6: fire without arm
    tag = "R6";
    idle(3);
    wr_byte(8'hAA);
    chk(wdr == 1'b1, "R6", "unarmed 0xAA", wdr, 1);

    // R8: event clears armed state
    tag = "R8";
    idle(2);
    wr_byte(8'h55); wr_byte(8'h00);
    chk(wdr == 1'b1, "R8", "fault after arm", wdr, 1);
    wr_byte(8'hAA);
    chk(wdr == 1'b1, "R8", "0xAA after event", wdr, 1);

    // R7: window mode
    tag = "R7";
    restart(3'd1, 1'b1);
    idle(5);
    wr_byte(8'h55);
    chk(wdr == 1'b1, "R7", "early write", wdr, 1);
    idle(23);
    wr_byte(8'h55);
    chk(wdr == 1'b1, "R7", "write one below boundary", wdr, 1);
    idle(24);
    wr_byte(8'h55);
    chk(wdr == 1'b0, "R7", "arm at boundary", wdr, 0);
    wr_byte(8'hAA);
    chk(wdr == 1'b0, "R7", "fire in window", wdr, 0);
    wait_pulse(n);
    chk(n == 32, "R7", "period after windowed service", n, 32);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule